// File: doc/BRIEF.md
# Double-Buffered Octal Channel Register Decoder

This block sits behind a serial front end and turns each received command into updates of a bank of channel registers. Every channel has two registers: a staging (input) register that software preloads, and a live (output) register whose value drives the converter for that channel. A command carries a channel address, a three-bit control code and a data byte. It can preload one staging register, write one channel straight through to its live register, write the same byte to every live register, copy all staging registers to the live side at once, clear everything, or put selected channels to sleep.

An active-low hardware load input, which may be asynchronous to the system clock, is synchronised inside the block. While it is held active, every live register tracks its staging register, including staging writes made during that time. The block also holds the sleep state and per-channel enable mask, and it issues a one-cycle request, with the selected edge, that tells the serial front end to change the edge on which it shifts out data.

Top module: `dac_bank_ctrl`

## Requirements
- R1: After reset every live register reads zero, all channel enables are one, the sleep flag is zero, the edge-select output is zero and no edge-change request is raised.
- R2: Control code 000 changes no staging register, no live register, no sleep state and no edge select, whatever the address and data bits.
- R3: Control code 001 sets every staging and every live register to zero and leaves the sleep state.
- R4: Control code 010 enters sleep: the sleep flag goes to one and channel enable bit i takes data bit i, so a zero data byte disables every channel; while awake every enable bit is one.
- R5: Control code 011 raises the edge-change request for exactly one cycle, sets the edge select to the most significant address bit (0 falling, 1 rising) and copies every staging register into its live register.
- R6: Control code 100 writes the data byte into every live register, leaves staging registers unchanged and leaves sleep.
- R7: Control code 101 writes the data byte into the staging register of the addressed channel only and changes no live register and no sleep state.
- R8: Control code 110 writes the data byte into both the staging and the live register of the addressed channel, changes no other channel and leaves sleep.
- R9: Control code 111 copies every staging register into its live register.
- R10: Once the hardware load input has been low at three rising clock edges, every live register equals its staging register after each following edge, including staging writes made while it stays low; the effect stops within three edges of its release.
- R11: A command presented with the valid strobe low has no effect.
- R12: Only control codes 001, 100 and 110 take the block out of sleep; codes 000, 011, 101 and 111 leave the sleep state and mask as they are.
- R13: Every command takes effect at the clock edge on which it is presented valid and is visible on the outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle while high |
| cmd_addr_i | input | 3 | Channel address (ADDR_W) |
| cmd_ctrl_i | input | 3 | Control code |
| cmd_data_i | input | 8 | Data byte (DW) |
| hw_load_n_i | input | 1 | Active-low hardware load, asynchronous |
| dac_code_o | output | 64 | Live registers, channel i in bits i*DW +: DW |
| chan_en_o | output | 8 | Per-channel enable |
| sleep_o | output | 1 | Block is in sleep |
| edge_sel_o | output | 1 | Stored edge select for the serial output, 1 = rising |
| edge_req_o | output | 1 | One-cycle request to apply edge_sel_o |

## Verification
The bench builds the block with its default parameters: eight channels of eight bits and a two-stage synchroniser for the hardware load. With those values the three address bits reach every channel exactly once, each data bit maps onto a channel enable so masks like all-zero and alternating patterns hit real channels, and the load path has a fixed three-edge latency that the bench can count exactly on assertion and on release.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [2:0] {
        CTL_NOP     = 3'b000,
        CTL_CLEAR   = 3'b001,
        CTL_SLEEP   = 3'b010,
        CTL_EDGE    = 3'b011,
        CTL_BCAST   = 3'b100,
        CTL_PRELOAD = 3'b101,
        CTL_LOADUPD = 3'b110,
        CTL_XFER    = 3'b111
    } ctl_e;

    // One-hot style strobes produced by the command decoder
    typedef struct packed {
        logic clear_all;
        logic sleep;
        logic edge_set;
        logic bcast;
        logic wr_stage;
        logic wr_live;
        logic xfer_all;
        logic wake;
    } dec_t;

endpackage

// File: rtl/dbc_load_sync.sv
module dbc_load_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n_i,
    output logic load_act_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], load_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{chain: '1};
        else        s_q <= s_d;
    end

    assign load_act_o = ~s_q.chain[STAGES-1];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2); // R10
    end
endmodule

// File: rtl/dbc_cmd_decode.sv
module dbc_cmd_decode
    import dbc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = $clog2(NCH)
) (
    input  logic              valid_i,
    input  logic [2:0]        ctrl_i,
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o,
    output logic [NCH-1:0]    sel_o
);
    always_comb begin
        dec_o = '0;
        if (valid_i) begin
            unique case (ctl_e'(ctrl_i))
                CTL_NOP:     ;
                CTL_CLEAR:   begin dec_o.clear_all = 1'b1; dec_o.wake = 1'b1; end
                CTL_SLEEP:   dec_o.sleep    = 1'b1;
                CTL_EDGE:    begin dec_o.edge_set = 1'b1; dec_o.xfer_all = 1'b1; end
                CTL_BCAST:   begin dec_o.bcast = 1'b1; dec_o.wake = 1'b1; end
                CTL_PRELOAD: dec_o.wr_stage = 1'b1;
                CTL_LOADUPD: begin dec_o.wr_stage = 1'b1; dec_o.wr_live = 1'b1; dec_o.wake = 1'b1; end
                CTL_XFER:    dec_o.xfer_all = 1'b1;
                default:     ;
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_sel
        assign sel_o[i] = (addr_i == ADDR_W'(i));
    end
endmodule

// File: rtl/dbc_reg_bank.sv
module dbc_reg_bank
    import dbc_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec_i,
    input  logic [NCH-1:0]    sel_i,
    input  logic [DW-1:0]     data_i,
    input  logic              load_act_i,
    output logic [NCH*DW-1:0] live_o
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] stage;
        logic [NCH-1:0][DW-1:0] live;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (dec_i.clear_all) begin
            b_d.stage = '0;
            b_d.live  = '0;
        end
        for (int i = 0; i < NCH; i++) begin
            if (dec_i.wr_stage && sel_i[i]) b_d.stage[i] = data_i;
            if (dec_i.wr_live  && sel_i[i]) b_d.live[i]  = data_i;
            if (dec_i.bcast)                b_d.live[i]  = data_i;
        end
        if (dec_i.xfer_all) b_d.live = b_q.stage;
        // hardware load: live follows the staging value of this same edge
        if (load_act_i)     b_d.live = b_d.stage;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign live_o = b_q.live;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i.clear_all |=> (b_q.live == '0 && b_q.stage == '0)); // R3
    AST_PRELOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i.wr_stage && !dec_i.wr_live && !load_act_i) |=> $stable(live_o)); // R7
    AST_LOAD_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        load_act_i |=> (b_q.live == b_q.stage)); // R10
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_i)); // R8
endmodule

// File: rtl/dbc_power_ctrl.sv
module dbc_power_ctrl
    import dbc_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DW     = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     data_i,
    output logic [NCH-1:0]    en_o,
    output logic              sleep_o,
    output logic              edge_sel_o,
    output logic              edge_req_o
);
    typedef struct packed {
        logic           asleep;
        logic [NCH-1:0] mask;
        logic           edge_sel;
        logic           edge_req;
    } pwr_t;

    pwr_t p_d, p_q;
    logic [NCH-1:0] mask_in;

    for (genvar i = 0; i < NCH; i++) begin : g_mask
        if (i < DW) begin : g_bit
            assign mask_in[i] = data_i[i];
        end else begin : g_zero
            assign mask_in[i] = 1'b0;
        end
    end

    always_comb begin
        p_d = p_q;
        p_d.edge_req = 1'b0;
        if (dec_i.sleep) begin
            p_d.asleep = 1'b1;
            p_d.mask   = mask_in;
        end
        if (dec_i.wake) p_d.asleep = 1'b0;
        if (dec_i.edge_set) begin
            p_d.edge_sel = addr_i[ADDR_W-1];
            p_d.edge_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{asleep: 1'b0, mask: '1, edge_sel: 1'b0, edge_req: 1'b0};
        else        p_q <= p_d;
    end

    assign en_o       = p_q.asleep ? p_q.mask : '1;
    assign sleep_o    = p_q.asleep;
    assign edge_sel_o = p_q.edge_sel;
    assign edge_req_o = p_q.edge_req;

    logic sleep_cmd, wake_cmd, edge_cmd;
    assign sleep_cmd = dec_i.sleep;
    assign wake_cmd  = dec_i.wake;
    assign edge_cmd  = dec_i.edge_set;

    AST_SLEEP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_cmd |=> (sleep_o && en_o == $past(mask_in))); // R4
    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_cmd |=> !sleep_o); // R12
    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_req_o |-> $past(edge_cmd)); // R5
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_cmd |=> $stable(edge_sel_o)); // R5
endmodule

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
    import dbc_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [2:0]        cmd_ctrl_i,
    input  logic [DW-1:0]     cmd_data_i,
    input  logic              hw_load_n_i,
    output logic [NCH*DW-1:0] dac_code_o,
    output logic [NCH-1:0]    chan_en_o,
    output logic              sleep_o,
    output logic              edge_sel_o,
    output logic              edge_req_o
);
    dec_t           dec;
    logic [NCH-1:0] sel;
    logic           load_act;

    dbc_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n_i   (hw_load_n_i),
        .load_act_o (load_act)
    );

    dbc_cmd_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
        .valid_i (cmd_valid_i),
        .ctrl_i  (cmd_ctrl_i),
        .addr_i  (cmd_addr_i),
        .dec_o   (dec),
        .sel_o   (sel)
    );

    dbc_reg_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_i      (dec),
        .sel_i      (sel),
        .data_i     (cmd_data_i),
        .load_act_i (load_act),
        .live_o     (dac_code_o)
    );

    dbc_power_ctrl #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_i      (dec),
        .addr_i     (cmd_addr_i),
        .data_i     (cmd_data_i),
        .en_o       (chan_en_o),
        .sleep_o    (sleep_o),
        .edge_sel_o (edge_sel_o),
        .edge_req_o (edge_req_o)
    );

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid_i && !load_act) |=> ($stable(dac_code_o) && $stable(chan_en_o) && $stable(sleep_o))); // R11
endmodule

// File: tb/dac_bank_ctrl_bench.sv
module dac_bank_ctrl_bench;
    localparam int NCH = 8;
    localparam int DW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid_i = 1'b0;
    logic [2:0] cmd_addr_i = '0;
    logic [2:0] cmd_ctrl_i = '0;
    logic [DW-1:0] cmd_data_i = '0;
    logic hw_load_n_i = 1'b1;
    logic [NCH*DW-1:0] dac_code_o;
    logic [NCH-1:0] chan_en_o;
    logic sleep_o, edge_sel_o, edge_req_o;

    dac_bank_ctrl u_dac_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_addr_i(cmd_addr_i),
        .cmd_ctrl_i(cmd_ctrl_i), .cmd_data_i(cmd_data_i), .hw_load_n_i(hw_load_n_i),
        .dac_code_o(dac_code_o), .chan_en_o(chan_en_o), .sleep_o(sleep_o),
        .edge_sel_o(edge_sel_o), .edge_req_o(edge_req_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] stage_m [NCH];
    logic [DW-1:0] live_m  [NCH];
    logic          sleep_m, edge_m, req_m, transp_m;
    logic [NCH-1:0] mask_m;

    function automatic logic [NCH-1:0] exp_en();
        return sleep_m ? mask_m : '1;
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd0: return "R2";   3'd1: return "R3";
            3'd2: return "R4";   3'd3: return "R5";
            3'd4: return "R6";   3'd5: return "R7";
            3'd6: return "R8";   default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin stage_m[i] = '0; live_m[i] = '0; end
        sleep_m = 0; edge_m = 0; req_m = 0; transp_m = 0; mask_m = '1;
    endtask

    task automatic model_apply(input logic v, input logic [2:0] a, input logic [2:0] c, input logic [DW-1:0] d);
        req_m = 0;
        if (v) begin
            case (c)
                3'd1: begin for (int i = 0; i < NCH; i++) begin stage_m[i] = '0; live_m[i] = '0; end sleep_m = 0; end
                3'd2: begin sleep_m = 1; mask_m = d; end
                3'd3: begin edge_m = a[2]; req_m = 1; for (int i = 0; i < NCH; i++) live_m[i] = stage_m[i]; end
                3'd4: begin for (int i = 0; i < NCH; i++) live_m[i] = d; sleep_m = 0; end
                3'd5: stage_m[a] = d;
                3'd6: begin stage_m[a] = d; live_m[a] = d; sleep_m = 0; end
                3'd7: for (int i = 0; i < NCH; i++) live_m[i] = stage_m[i];
                default: ;
            endcase
        end
        if (transp_m) for (int i = 0; i < NCH; i++) live_m[i] = stage_m[i];
    endtask

    task automatic check_all(input string tag);
        logic ok;
        ok = 1;
        checks++;
        for (int i = 0; i < NCH; i++)
            if (dac_code_o[i*DW +: DW] !== live_m[i]) begin
                ok = 0;
                $display("FAIL %s: channel %0d code got %h exp %h", tag, i, dac_code_o[i*DW +: DW], live_m[i]);
            end
        if (chan_en_o !== exp_en()) begin
            ok = 0; $display("FAIL %s: chan_en got %b exp %b", tag, chan_en_o, exp_en());
        end
        if (sleep_o !== sleep_m) begin
            ok = 0; $display("FAIL %s: sleep got %b exp %b", tag, sleep_o, sleep_m);
        end
        if (edge_sel_o !== edge_m || edge_req_o !== req_m) begin
            ok = 0; $display("FAIL %s: edge sel/req got %b/%b exp %b/%b", tag, edge_sel_o, edge_req_o, edge_m, req_m);
        end
        if (!ok) fails++;
    endtask

    // drive at negedge, clock, update model, check at next negedge (R13)
    task automatic step(input logic v, input logic [2:0] a, input logic [2:0] c, input logic [DW-1:0] d, input string tag);
        cmd_valid_i = v; cmd_addr_i = a; cmd_ctrl_i = c; cmd_data_i = d;
        @(posedge clk);
        model_apply(v, a, c, d);
        @(negedge clk);
        cmd_valid_i = 0;
        check_all(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        step(1, 3, 3'd5, 8'h5A, "R7");          // preload ch3 only
        step(1, 0, 3'd7, 8'hFF, "R9");          // software transfer
        step(1, 6, 3'd6, 8'h81, "R8");          // load and update ch6
        step(1, 7, 3'd0, 8'hC3, "R2");          // no-op with junk
        step(0, 2, 3'd1, 8'h00, "R11");         // clear without strobe
        step(1, 1, 3'd4, 8'h33, "R6");          // broadcast live only
        step(1, 0, 3'd7, 8'h00, "R6");          // staging kept: transfer restores
        step(1, 0, 3'd2, 8'hA5, "R4");          // sleep with mask
        step(1, 2, 3'd5, 8'h44, "R12");         // preload keeps sleep
        step(1, 0, 3'd7, 8'h00, "R12");         // transfer keeps sleep
        step(1, 4, 3'd3, 8'h00, "R12");         // edge command keeps sleep
        step(1, 0, 3'd0, 8'h00, "R5");          // request falls after one cycle
        step(1, 5, 3'd6, 8'h9C, "R12");         // load-update wakes
        step(1, 0, 3'd2, 8'h00, "R4");          // full sleep: all disabled
        step(1, 0, 3'd4, 8'h07, "R12");         // broadcast wakes
        step(1, 0, 3'd2, 8'h3C, "R4");
        step(1, 0, 3'd1, 8'hEE, "R3");          // clear wakes and zeroes
        step(1, 3, 3'd3, 8'h00, "R5");          // edge select back to falling

        // hardware load (R10)
        step(1, 1, 3'd5, 8'h11, "R10");
        hw_load_n_i = 0;
        step(0, 0, 3'd0, 8'h00, "R10");
        step(0, 0, 3'd0, 8'h00, "R10");
        transp_m = 1;
        step(0, 0, 3'd0, 8'h00, "R10");         // third edge: transparent
        step(1, 2, 3'd5, 8'h22, "R10");         // staging write follows at once
        step(1, 4, 3'd4, 8'h77, "R10");         // broadcast overridden by staging
        hw_load_n_i = 1;
        step(1, 5, 3'd5, 8'h55, "R10");
        step(1, 6, 3'd5, 8'h66, "R10");
        transp_m = 0;
        step(1, 7, 3'd5, 8'h70, "R10");         // no longer transparent

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic v;
            logic [2:0] c;
            v = ($urandom % 8) != 0;
            c = 3'($urandom);
            if (c == 3'd1 && ($urandom % 4) != 0) c = 3'd5;
            step(v, 3'($urandom), c, 8'($urandom), v ? tag_of(c) : "R11");
        end
        finish_run();
    end
endmodule